// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave Controller

This block is the bus side of a 1024-byte serial EEPROM. It runs on a fast system clock and samples the two-wire clock (SCL) and data (SDA) lines through synchronisers. It finds start and stop conditions and shifts bytes in and out, most significant bit first. It answers only to its own device header, and it drives acknowledge and read data onto SDA through a single active-low pull-down enable. It does not store array contents. Each accepted data byte is passed to a memory back end through a one-cycle write strobe. Each byte to be sent is fetched through a one-cycle read strobe, and the data is returned on the following clock.

The header byte holds a fixed 4-bit type code, one device-select bit that is compared with a strap input, the two most significant array address bits, and a direction bit. A write carries one more byte, the low eight address bits, followed by any number of data bytes. The block keeps its own 10-bit address counter. Writes advance the counter within a 16-byte page. Reads advance it across the whole array. This supports byte and page writes, current-address reads, random reads (a write header plus address, then a repeated start and a read header) and sequential reads. After a write transaction the back end runs its internal programming cycle and raises a busy input. While busy is high the slave ignores its own address, so the host can poll for completion.

The SCL low and high phases must each last at least 8 system clocks.

Top module: `twi_ee_slave`

## Requirements
- R1: A start condition is SDA falling while SCL is high, and it is detected in any state. It abandons the current transfer, so a partly received data byte is never written, and header reception begins again.
- R2: After reset SDA is released (sda_pd_n_o = 1). Until a start condition is seen, bytes clocked on the bus are not acknowledged.
- R3: Header layout, MSB first: bits 7:4 = 4'b1010, bit 3 = dev_sel_i, bits 2:1 = address bits 9:8, bit 0 = 1 for read and 0 for write. On a match the slave pulls SDA low during the ninth clock. On a mismatch it stays released and ignores the bus until the next start.
- R4: In a write, the second byte is address bits 7:0 and is joined with the two header bits to form the 10-bit address. Each following byte is acknowledged and issued with mem_wr_o at the current address.
- R5: After each written byte only address bits 3:0 increment, wrapping from 15 to 0. Bits 9:4 are unchanged, so more than 16 bytes overwrite the start of the same page.
- R6: In a read the slave drives 8 data bits, MSB first, and then releases SDA for the ninth clock. If the master drives SDA low there, the next byte follows. If the master leaves SDA high, the slave stays released until the next start or stop.
- R7: Each byte sent advances the full 10-bit address by one, wrapping from 1023 to 0.
- R8: A read header loads its two address bits into bits 9:8 of the counter and returns data from the resulting address. After any access to address n, a read returns address n+1 (within the page for writes). A write header plus address, followed by a repeated start and a read header, reads the loaded address.
- R9: While wr_busy_i is high the slave does not acknowledge any header and issues no mem_wr_o.
- R10: A stop condition (SDA rising while SCL is high) returns the slave to idle. If at least one data byte was written since the previous stop, wr_commit_o pulses for one cycle; a transfer carrying only an address does not pulse it.
- R11: sda_pd_n_o changes only while the synchronised SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Two-wire clock line (asynchronous) |
| sda_i | input | 1 | Two-wire data line as seen on the pad (asynchronous) |
| dev_sel_i | input | 1 | Strap value compared with header bit 3 |
| sda_pd_n_o | output | 1 | 0 = pull SDA low, 1 = release |
| mem_addr_o | output | 10 | Current array address (internal counter) |
| mem_wr_o | output | 1 | One-cycle write strobe to the back end |
| mem_wdata_o | output | 8 | Byte to be written |
| mem_rd_o | output | 1 | One-cycle read strobe to the back end |
| mem_rdata_i | input | 8 | Read data, valid the cycle after mem_rd_o |
| wr_busy_i | input | 1 | Back end programming cycle in progress |
| wr_commit_o | output | 1 | One-cycle pulse at a stop that ends a write with data |

## Verification
Several rules are checked by assertions on every cycle:
- the pull-down is active only in an acknowledge or transmit slot;
- it never changes while synchronised SCL is high;
- no write strobe is issued while busy;
- the read and write strobes never coincide;
- a stop always returns the controller to idle;
- a commit pulse only follows a stop;
- a page write leaves the upper address bits alone.

Other behaviour can only be shown by the bench's end-to-end scenarios, driven against a memory model with arithmetically derived contents. These scenarios cover address matching, the address arithmetic (page wrap, array wrap, current-address continuity), the data returned by random and sequential reads, abort by a repeated start, and silence during busy polling.

// File: rtl/twi_ee_pkg.sv
package twi_ee_pkg;
  // Header bits that extend the word address; the header layout fixes this.
  localparam int HDR_HI_W = 2;
  localparam int ADDR_W   = 8 + HDR_HI_W;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_HDR,
    ST_HDR_ACK,
    ST_WADDR,
    ST_WADDR_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_TX,
    ST_RACK,
    ST_IGNORE
  } twi_state_e;
endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic              scl_q;
  logic              sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_q    <= scl_s;
      sda_q    <= sda_s;
    end
  end

  assign scl_s    = scl_pipe[STAGES-1];
  assign sda_s    = sda_pipe[STAGES-1];
  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
  // Conditions need SCL high on both samples around the SDA change.
  assign start_ev = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_ev  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/twi_ee_addr_ctr.sv
module twi_ee_addr_ctr
  import twi_ee_pkg::*;
#(
  parameter int PAGE_W = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ld_full,
  input  logic [ADDR_W-1:0]   full_val,
  input  logic                ld_hi,
  input  logic [HDR_HI_W-1:0] hi_val,
  input  logic                inc_page,
  input  logic                inc_seq,
  output logic [ADDR_W-1:0]   addr_o
);
  // Write-side step: only the in-page offset moves.
  function automatic logic [ADDR_W-1:0] page_step(input logic [ADDR_W-1:0] a);
    page_step = {a[ADDR_W-1:PAGE_W], a[PAGE_W-1:0] + PAGE_W'(1)};
  endfunction

  // Read-side step: the whole array, wrapping at the top.
  function automatic logic [ADDR_W-1:0] array_step(input logic [ADDR_W-1:0] a);
    array_step = a + ADDR_W'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        addr_o <= '0;
    else if (ld_full)  addr_o <= full_val;
    else if (ld_hi)    addr_o <= {hi_val, addr_o[ADDR_W-HDR_HI_W-1:0]};
    else if (inc_page) addr_o <= page_step(addr_o);
    else if (inc_seq)  addr_o <= array_step(addr_o);
  end

  // R5: a page step never touches the page number.
  assert_page_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_page && !ld_full && !ld_hi) |=> addr_o[ADDR_W-1:PAGE_W] == $past(addr_o[ADDR_W-1:PAGE_W]));
endmodule

// File: rtl/twi_ee_slave.sv
module twi_ee_slave
  import twi_ee_pkg::*;
#(
  parameter int         PAGE_W      = 4,
  parameter int         SYNC_STAGES = 2,
  parameter logic [3:0] TYPE_ID     = 4'b1010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              dev_sel_i,
  output logic              sda_pd_n_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_wr_o,
  output logic [7:0]        mem_wdata_o,
  output logic              mem_rd_o,
  input  logic [7:0]        mem_rdata_i,
  input  logic              wr_busy_i,
  output logic              wr_commit_o
);
  localparam logic [3:0] BITS_PER_BYTE = 4'd8;

  // Line events
  logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;

  twi_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .scl_s    (scl_s),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_ev (start_ev),
    .stop_ev  (stop_ev)
  );

  twi_state_e          st;
  logic [3:0]          bit_cnt;
  logic [7:0]          shreg;
  logic [7:0]          rbuf;
  logic                rd_kick;
  logic                rd_pend;
  logic                hdr_rd;
  logic [HDR_HI_W-1:0] hdr_hi;
  logic                wrote;
  logic                mack;

  // Header decode
  function automatic logic hdr_matches(input logic [7:0] b, input logic sel);
    hdr_matches = (b[7:4] == TYPE_ID) && (b[3] == sel);
  endfunction

  // Named internal events
  logic byte_done, rx_state, byte_end, hdr_ok;
  logic ld_full, ld_hi, inc_page, inc_seq;

  assign byte_done = (bit_cnt == BITS_PER_BYTE);
  assign rx_state  = (st == ST_HDR) || (st == ST_WADDR) || (st == ST_WDATA);
  assign byte_end  = rx_state && scl_fall && byte_done && !start_ev && !stop_ev;
  assign hdr_ok    = hdr_matches(shreg, dev_sel_i) && !wr_busy_i;
  assign ld_full   = byte_end && (st == ST_WADDR);
  assign ld_hi     = byte_end && (st == ST_HDR) && hdr_ok && shreg[0];
  assign inc_page  = byte_end && (st == ST_WDATA);
  assign inc_seq   = (st == ST_TX) && scl_fall && (bit_cnt == 4'd7) && !start_ev && !stop_ev;

  twi_ee_addr_ctr #(.PAGE_W(PAGE_W)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld_full  (ld_full),
    .full_val ({hdr_hi, shreg}),
    .ld_hi    (ld_hi),
    .hi_val   (shreg[2:1]),
    .inc_page (inc_page),
    .inc_seq  (inc_seq),
    .addr_o   (mem_addr_o)
  );

  assign mem_wr_o    = inc_page;
  assign mem_wdata_o = shreg;
  assign mem_rd_o    = rd_kick;

  // Read fetch: strobe one cycle after the counter settles, capture one later.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_kick <= 1'b0;
      rd_pend <= 1'b0;
      rbuf    <= '0;
    end else begin
      rd_kick <= ld_hi || inc_seq;
      rd_pend <= rd_kick;
      if (rd_pend) rbuf <= mem_rdata_i;
    end
  end

  // Commit pulse
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_commit_o <= 1'b0;
    else        wr_commit_o <= stop_ev && wrote;
  end

  // Protocol sequencer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      bit_cnt    <= '0;
      shreg      <= '0;
      sda_pd_n_o <= 1'b1;
      hdr_rd     <= 1'b0;
      hdr_hi     <= '0;
      wrote      <= 1'b0;
      mack       <= 1'b0;
    end else if (start_ev) begin
      st         <= ST_HDR;
      bit_cnt    <= '0;
      sda_pd_n_o <= 1'b1;
    end else if (stop_ev) begin
      st         <= ST_IDLE;
      sda_pd_n_o <= 1'b1;
      wrote      <= 1'b0;
    end else begin
      unique case (st)
        ST_HDR, ST_WADDR, ST_WDATA: begin
          if (scl_rise && !byte_done) begin
            shreg   <= {shreg[6:0], sda_s};
            bit_cnt <= bit_cnt + 4'd1;
          end else if (byte_end) begin
            bit_cnt <= '0;
            if (st == ST_HDR) begin
              if (hdr_ok) begin
                sda_pd_n_o <= 1'b0;
                st         <= ST_HDR_ACK;
                hdr_rd     <= shreg[0];
                hdr_hi     <= shreg[2:1];
              end else begin
                st <= ST_IGNORE;
              end
            end else if (st == ST_WADDR) begin
              sda_pd_n_o <= 1'b0;
              st         <= ST_WADDR_ACK;
            end else begin
              sda_pd_n_o <= 1'b0;
              st         <= ST_WDATA_ACK;
              wrote      <= 1'b1;
            end
          end
        end
        ST_HDR_ACK, ST_WADDR_ACK, ST_WDATA_ACK: begin
          if (scl_fall) begin
            if (st == ST_HDR_ACK && hdr_rd) begin
              shreg      <= rbuf;
              sda_pd_n_o <= rbuf[7];
              bit_cnt    <= '0;
              st         <= ST_TX;
            end else begin
              sda_pd_n_o <= 1'b1;
              st         <= (st == ST_HDR_ACK) ? ST_WADDR : ST_WDATA;
            end
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (bit_cnt == 4'd7) begin
              sda_pd_n_o <= 1'b1;
              st         <= ST_RACK;
            end else begin
              sda_pd_n_o <= shreg[6];
              shreg      <= {shreg[6:0], 1'b0};
              bit_cnt    <= bit_cnt + 4'd1;
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) mack <= ~sda_s;
          else if (scl_fall) begin
            if (mack) begin
              shreg      <= rbuf;
              sda_pd_n_o <= rbuf[7];
              bit_cnt    <= '0;
              st         <= ST_TX;
            end else begin
              st <= ST_IGNORE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  // R3/R6: the pull-down is only active in an acknowledge or transmit slot.
  assert_pull_in_slot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !sda_pd_n_o |-> (st inside {ST_HDR_ACK, ST_WADDR_ACK, ST_WDATA_ACK, ST_TX}));

  // R11: no SDA change while the sampled SCL stays high.
  assert_quiet_scl_high_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && $past(scl_s) && !$past(start_ev) && !$past(stop_ev)) |-> $stable(sda_pd_n_o));

  // R9: busy back end never receives a write.
  assert_busy_no_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_busy_i |-> !mem_wr_o);

  // R6: fetch and store strobes are exclusive.
  assert_rd_wr_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_o && mem_wr_o));

  // R10: stop leads to idle, commit only follows a stop.
  assert_stop_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> (st == ST_IDLE));
  assert_commit_after_stop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit_o |-> $past(stop_ev));
endmodule

// File: tb/twi_ee_slave_tb_top.sv
module twi_ee_slave_tb_top;
  localparam int H        = 40;
  localparam int BUSY_CYC = 2000;
  localparam int WDOG     = 190000;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       m_scl = 1'b1;
  logic       m_sda = 1'b1;
  logic       sda_pd_n;
  logic [9:0] mem_addr;
  logic       mem_wr, mem_rd, wr_commit;
  logic [7:0] mem_wdata;
  logic [7:0] mem_rdata = '0;
  logic       wr_busy;
  int         busy_cnt = 0;
  wire        sda_line = m_sda & sda_pd_n;

  twi_ee_slave dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_i       (m_scl),
    .sda_i       (sda_line),
    .dev_sel_i   (1'b1),
    .sda_pd_n_o  (sda_pd_n),
    .mem_addr_o  (mem_addr),
    .mem_wr_o    (mem_wr),
    .mem_wdata_o (mem_wdata),
    .mem_rd_o    (mem_rd),
    .mem_rdata_i (mem_rdata),
    .wr_busy_i   (wr_busy),
    .wr_commit_o (wr_commit)
  );

  // Back end model and expected image
  logic [7:0] mem  [1024];
  logic [7:0] gold [1024];
  int n_wr = 0, n_commit = 0, n_chk = 0, n_bad = 0, n_hi_glitch = 0;
  bit done = 0;

  function automatic logic [7:0] seed_val(input int i);
    seed_val = 8'((i * 37) + (i >> 3));
  endfunction

  assign wr_busy = (busy_cnt != 0);

  always @(posedge clk) begin
    if (mem_wr) begin mem[mem_addr] <= mem_wdata; n_wr <= n_wr + 1; end
    if (mem_rd) mem_rdata <= mem[mem_addr];
    if (wr_commit) begin n_commit <= n_commit + 1; busy_cnt <= BUSY_CYC; end
    else if (busy_cnt != 0) busy_cnt <= busy_cnt - 1;
  end

  // R11 monitor at the ports
  logic prev_scl = 1'b1, prev_pd = 1'b1;
  always @(negedge clk) begin
    if (rst_n && m_scl && prev_scl && (sda_pd_n != prev_pd)) n_hi_glitch++;
    prev_scl = m_scl;
    prev_pd  = sda_pd_n;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hw(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    hw(H/2); m_sda = 1'b1; hw(H); m_scl = 1'b1; hw(H); m_sda = 1'b0; hw(H); m_scl = 1'b0;
  endtask

  task automatic bus_stop();
    hw(H/2); m_sda = 1'b0; hw(H); m_scl = 1'b1; hw(H); m_sda = 1'b1; hw(H);
  endtask

  task automatic send_bit(input bit b);
    hw(H/2); m_sda = b; hw(H/2); m_scl = 1'b1; hw(H); m_scl = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    hw(H/2); m_sda = 1'b1; hw(H/2); m_scl = 1'b1; hw(H/2);
    ack = !sda_line;
    hw(H/2); m_scl = 1'b0;
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] d);
    d = '0;
    hw(H/2); m_sda = 1'b1;
    for (int i = 0; i < 8; i++) begin
      hw(H/2); m_scl = 1'b1; hw(H/2);
      d = {d[6:0], sda_line};
      hw(H/2); m_scl = 1'b0;
    end
    hw(H/2); m_sda = !give_ack; hw(H/2); m_scl = 1'b1; hw(H); m_scl = 1'b0;
    hw(H/2); m_sda = 1'b1;
  endtask

  function automatic logic [7:0] hdr(input logic [1:0] pg, input bit rd);
    hdr = {4'b1010, 1'b1, pg, rd};
  endfunction

  task automatic wait_idle();
    hw(4);
    while (wr_busy) hw(1);
  endtask

  // Write n bytes from address a; expected image follows the in-page wrap.
  task automatic write_seq(input logic [9:0] a, input int n, input logic [7:0] sd);
    bit ack;
    bus_start();
    send_byte(hdr(a[9:8], 1'b0), ack); check(ack, "R3 write header ack", ack, 1);
    send_byte(a[7:0], ack);            check(ack, "R4 word address ack", ack, 1);
    for (int k = 0; k < n; k++) begin
      logic [7:0] v;
      logic [9:0] wa;
      v  = 8'(sd + k * 13);
      wa = {a[9:4], 4'(a[3:0] + k)};
      send_byte(v, ack);
      if (!ack) check(0, "R4 data byte ack", k, 1);
      gold[wa] = v;
    end
    bus_stop();
  endtask

  // Random read of n bytes from a; acknowledges all but the last.
  task automatic read_seq(input logic [9:0] a, input int n, input bit rnd, input string req);
    bit ack;
    logic [7:0] d;
    bus_start();
    if (rnd) begin
      send_byte(hdr(a[9:8], 1'b0), ack); check(ack, "R8 dummy header ack", ack, 1);
      send_byte(a[7:0], ack);            check(ack, "R8 dummy address ack", ack, 1);
      bus_start();
    end
    send_byte(hdr(a[9:8], 1'b1), ack); check(ack, "R6 read header ack", ack, 1);
    for (int k = 0; k < n; k++) begin
      logic [9:0] ra;
      ra = 10'(a + k);
      recv_byte(k != n - 1, d);
      check(d == gold[ra], req, d, gold[ra]);
    end
    check(sda_pd_n == 1'b1, "R6 released after nack", sda_pd_n, 1);
    bus_stop();
  endtask

  initial begin
    bit ack;
    int wr0, cm0;
    for (int i = 0; i < 1024; i++) begin mem[i] = seed_val(i); gold[i] = seed_val(i); end
    hw(5);
    // Reset state
    check(sda_pd_n == 1'b1 && !mem_wr && !wr_commit, "R2 reset outputs", sda_pd_n, 1);
    rst_n = 1'b1;
    hw(10);

    // R2: no start, no answer
    m_scl = 1'b0;
    send_byte(hdr(2'b00, 1'b0), ack);
    check(!ack, "R2 byte without start unacked", ack, 0);
    bus_stop();

    // R3: wrong select bit, then wrong type
    bus_start();
    send_byte(8'b1010_0000, ack); check(!ack, "R3 select mismatch unacked", ack, 0);
    send_byte(8'h00, ack);        check(!ack, "R3 ignored after mismatch", ack, 0);
    bus_stop();
    bus_start();
    send_byte(8'b1011_1000, ack); check(!ack, "R3 type mismatch unacked", ack, 0);
    bus_stop();
    check(n_wr == 0, "R3 no writes after mismatch", n_wr, 0);

    // R4/R10: byte write at 0x2A5
    cm0 = n_commit;
    write_seq(10'h2A5, 1, 8'h5C);
    hw(4);
    check(n_commit == cm0 + 1, "R10 commit after write stop", n_commit, cm0 + 1);
    check(mem[10'h2A5] == gold[10'h2A5], "R4 byte written", mem[10'h2A5], gold[10'h2A5]);

    // R9: poll while busy
    wr0 = n_wr;
    bus_start();
    send_byte(hdr(2'b00, 1'b0), ack); check(!ack, "R9 no ack while busy", ack, 0);
    bus_stop();
    check(wr_busy == 1'b1, "R9 poll happened inside busy window", wr_busy, 1);
    wait_idle();
    bus_start();
    send_byte(hdr(2'b00, 1'b0), ack); check(ack, "R9 ack once idle", ack, 1);
    bus_stop();
    check(n_wr == wr0, "R9 no write during poll", n_wr, wr0);

    // R8: current address after byte write is 0x2A6
    read_seq(10'h2A6, 1, 1'b0, "R8 current read after write");

    // R5: page write of 18 bytes from 0x12E wraps inside page 0x120
    wait_idle();
    write_seq(10'h12E, 18, 8'h90);
    wait_idle();
    for (int j = 0; j < 16; j++)
      check(mem[10'h120 + j] == gold[10'h120 + j], "R5 page contents", mem[10'h120 + j], gold[10'h120 + j]);
    check(mem[10'h130] == gold[10'h130], "R5 next page untouched", mem[10'h130], gold[10'h130]);
    check(mem[10'h11F] == gold[10'h11F], "R5 previous page untouched", mem[10'h11F], gold[10'h11F]);

    // R8/R10: random read, no commit for address-only write phase
    cm0 = n_commit;
    read_seq(10'h12F, 1, 1'b1, "R8 random read data");
    read_seq(10'h130, 1, 1'b0, "R8 current read follows read");
    hw(4);
    check(n_commit == cm0, "R10 no commit without data", n_commit, cm0);

    // R7: sequential read across the array end
    read_seq(10'h3FD, 5, 1'b1, "R7 sequential across wrap");
    read_seq(10'h002, 2, 1'b0, "R7 current read after wrap");

    // R1: repeated start aborts a partial data byte
    wr0 = n_wr;
    bus_start();
    send_byte(hdr(2'b01, 1'b0), ack); check(ack, "R1 header before abort", ack, 1);
    send_byte(8'h40, ack);            check(ack, "R1 address before abort", ack, 1);
    send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
    bus_start();
    send_byte(hdr(2'b01, 1'b1), ack); check(ack, "R1 header after restart", ack, 1);
    begin
      logic [7:0] d;
      recv_byte(1'b0, d);
      check(d == gold[10'h140], "R1 read after abort", d, gold[10'h140]);
    end
    bus_stop();
    hw(4);
    check(n_wr == wr0, "R1 partial byte not written", n_wr, wr0);
    check(mem[10'h140] == gold[10'h140], "R1 memory unchanged", mem[10'h140], gold[10'h140]);

    // R11
    check(n_hi_glitch == 0, "R11 SDA steady while SCL high", n_hi_glitch, 0);

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog R1 actual=%0d expected=%0d", WDOG, 0);
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule